// File: doc/BRIEF.md
# Upward-Growing Stack Pointer Unit

This block owns the stack pointer of a small processor core. It keeps the 8-bit pointer and runs four kinds of stack traffic against the internal data RAM: single-byte push and pop, and subroutine entry and exit. Subroutine entry stores the multi-byte return address, and subroutine exit rebuilds it. The core may also overwrite the pointer with any value, for example to move the stack clear of the working register banks. The RAM, instruction fetch and interrupt handling are outside the block. The block drives the RAM port, and the core sees a busy level and a done pulse.

The stack grows toward higher addresses. The pointer always names the last occupied byte. A store first advances the pointer and then writes at the new address. A load first reads at the pointer and then steps it back. Each byte moves in one clock cycle. The RAM read path is combinational, so read data is taken in the same cycle that the address is presented.

Top module: `stack_unit`

## Requirements
- R1: After reset the pointer reads 07h, busy and done are low, and neither ram_we nor ram_re is asserted.
- R2: A push (op_code 1) accepted while idle gives one busy cycle. In that cycle ram_we is high, ram_addr is the pointer plus one and ram_wdata is data_in[7:0]. The pointer then holds that address, so the first push after reset writes address 08h.
- R3: A pop (op_code 2) gives one busy cycle. In that cycle ram_re is high and ram_addr equals the pointer. pop_data takes ram_rdata from that same cycle, and the pointer is decremented afterwards.
- R4: A call (op_code 3) gives two busy write cycles. The first writes ret_addr[7:0] at pointer+1 and the second writes ret_addr[15:8] at pointer+2. The pointer ends two higher.
- R5: A return (op_code 4) gives two busy read cycles. It reads the high byte at the pointer and then the low byte at pointer−1. ret_pc holds {high, low} and the pointer ends two lower.
- R6: A pointer load (op_code 5) writes data_in[7:0] into the pointer at the accepting clock edge. It makes no RAM access and raises no busy, and done pulses in the following cycle.
- R7: done is high for exactly one cycle, the cycle right after the last byte transfer of an operation, and busy is low in that cycle.
- R8: The pointer wraps modulo 256. A push at FFh writes address 00h, and a pop at 00h leaves FFh.
- R9: A request is ignored while busy is high. op_code 0, 6 and 7 are also ignored and produce no RAM access and no done. ram_we and ram_re are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Request strobe, sampled while idle |
| op_code | input | 3 | 1 push, 2 pop, 3 call, 4 return, 5 pointer load |
| data_in | input | 8 | Byte to push, or new pointer value |
| ret_addr | input | 16 | Return address saved by a call |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_addr | output | 8 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid in the same cycle as the address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pop_data | output | 8 | Byte recovered by the last pop |
| ret_pc | output | 16 | Address rebuilt by the last return |
| sp | output | 8 | Current stack pointer |

## Verification
Nested pushes and pops with distinct byte values show whether the pointer is advanced before the write and retreated after the read; an off-by-one in either direction recovers the wrong byte. Two nested calls unwound by two returns, with asymmetric return addresses, tell a correct byte order apart from a swapped one. Starting from a pointer loaded near FFh exercises the wrap in both directions. Requests given during busy cycles, and unused operation codes, must leave the RAM port, the pointer and done unchanged.

// File: rtl/stack_pkg.sv
package stack_pkg;
    localparam int unsigned STK_DATA_W = 8;
    localparam int unsigned STK_PC_W   = 16;
    localparam int unsigned STK_OP_W   = 3;

    typedef enum logic [STK_OP_W-1:0] {
        OP_NONE = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_CALL = 3'd3,
        OP_RET  = 3'd4,
        OP_MOVE = 3'd5
    } stk_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_POP,
        ST_CALL,
        ST_RET
    } stk_state_e;
endpackage

// File: rtl/stk_ptr_arith.sv
module stk_ptr_arith #(
    parameter int unsigned PTR_W = stack_pkg::STK_DATA_W
) (
    input  logic [PTR_W-1:0] ptr,
    output logic [PTR_W-1:0] ptr_up,
    output logic [PTR_W-1:0] ptr_down
);
    // Modulo arithmetic: carries and borrows fall off the top.
    always_comb begin
        ptr_up   = ptr + PTR_W'(1);
        ptr_down = ptr - PTR_W'(1);
    end
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stack_pkg::*;
#(
    parameter int unsigned DATA_W   = STK_DATA_W,
    parameter int unsigned PC_W     = STK_PC_W,
    parameter int unsigned RESET_SP = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [STK_OP_W-1:0] op_code,
    input  logic [DATA_W-1:0] data_in,
    input  logic [PC_W-1:0]   ret_addr,
    input  logic [DATA_W-1:0] ptr_up,
    input  logic [DATA_W-1:0] ptr_down,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              ram_we,
    output logic              ram_re,
    output logic [DATA_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] pop_data,
    output logic [PC_W-1:0]   ret_pc,
    output logic [DATA_W-1:0] sp
);
    localparam int unsigned NBYTES = PC_W / DATA_W;
    localparam int unsigned IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NBYTES - 1);

    typedef struct packed {
        stk_state_e        st;
        logic [DATA_W-1:0] sp;
        logic [PC_W-1:0]   hold;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] pop;
        logic [PC_W-1:0]   pc;
        logic              done;
    } regs_t;

    regs_t r_q, r_d;
    stk_op_e op_in;

    assign op_in = stk_op_e'(op_code);

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        ram_we     = 1'b0;
        ram_re     = 1'b0;
        ram_addr   = r_q.sp;
        ram_wdata  = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (op_valid) begin
                    unique case (op_in)
                        OP_PUSH: begin
                            r_d.st   = ST_PUSH;
                            r_d.hold = PC_W'(data_in);
                        end
                        OP_POP:  r_d.st = ST_POP;
                        OP_CALL: begin
                            r_d.st   = ST_CALL;
                            r_d.hold = ret_addr;
                            r_d.idx  = '0;
                        end
                        OP_RET: begin
                            r_d.st  = ST_RET;
                            r_d.idx = '0;
                        end
                        OP_MOVE: begin
                            r_d.sp   = data_in;
                            r_d.done = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            ST_PUSH: begin
                ram_we    = 1'b1;
                ram_addr  = ptr_up;
                ram_wdata = r_q.hold[DATA_W-1:0];
                r_d.sp    = ptr_up;
                r_d.st    = ST_IDLE;
                r_d.done  = 1'b1;
            end
            ST_POP: begin
                ram_re   = 1'b1;
                ram_addr = r_q.sp;
                r_d.pop  = ram_rdata;
                r_d.sp   = ptr_down;
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
            end
            ST_CALL: begin
                ram_we    = 1'b1;
                ram_addr  = ptr_up;
                ram_wdata = r_q.hold[r_q.idx*DATA_W +: DATA_W];
                r_d.sp    = ptr_up;
                if (r_q.idx == IDX_LAST) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.idx = r_q.idx + IDX_W'(1);
                end
            end
            ST_RET: begin
                ram_re   = 1'b1;
                ram_addr = r_q.sp;
                r_d.pc   = {r_q.pc[PC_W-DATA_W-1:0], ram_rdata};
                r_d.sp   = ptr_down;
                if (r_q.idx == IDX_LAST) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.idx = r_q.idx + IDX_W'(1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.sp   <= DATA_W'(RESET_SP);
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st != ST_IDLE);
    assign done     = r_q.done;
    assign pop_data = r_q.pop;
    assign ret_pc   = r_q.pc;
    assign sp       = r_q.sp;

    // A written address becomes the new pointer value.
    assert_push_advances_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> (sp == $past(ram_addr)));

    // A read address is left one below after the access.
    assert_pop_retreats_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_re |=> (sp == DATA_W'($past(ram_addr) - DATA_W'(1))));

    assert_pointer_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op_valid && op_code == OP_MOVE) |=> (sp == $past(data_in) && !busy && done));

    assert_done_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_single_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_we, ram_re}));

    assert_no_access_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(ram_we || ram_re));
endmodule

// File: rtl/stack_unit.sv
module stack_unit
    import stack_pkg::*;
#(
    parameter int unsigned DATA_W   = STK_DATA_W,
    parameter int unsigned PC_W     = STK_PC_W,
    parameter int unsigned RESET_SP = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [STK_OP_W-1:0] op_code,
    input  logic [DATA_W-1:0]   data_in,
    input  logic [PC_W-1:0]     ret_addr,
    output logic                ram_we,
    output logic                ram_re,
    output logic [DATA_W-1:0]   ram_addr,
    output logic [DATA_W-1:0]   ram_wdata,
    input  logic [DATA_W-1:0]   ram_rdata,
    output logic                busy,
    output logic                done,
    output logic [DATA_W-1:0]   pop_data,
    output logic [PC_W-1:0]     ret_pc,
    output logic [DATA_W-1:0]   sp
);
    logic [DATA_W-1:0] ptr_up, ptr_down;

    stk_ptr_arith #(.PTR_W(DATA_W)) u_arith (
        .ptr      (sp),
        .ptr_up   (ptr_up),
        .ptr_down (ptr_down)
    );

    stk_ctrl #(
        .DATA_W   (DATA_W),
        .PC_W     (PC_W),
        .RESET_SP (RESET_SP)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .data_in   (data_in),
        .ret_addr  (ret_addr),
        .ptr_up    (ptr_up),
        .ptr_down  (ptr_down),
        .ram_rdata (ram_rdata),
        .ram_we    (ram_we),
        .ram_re    (ram_re),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .busy      (busy),
        .done      (done),
        .pop_data  (pop_data),
        .ret_pc    (ret_pc),
        .sp        (sp)
    );
endmodule

// File: tb/stack_unit_test.sv
module stack_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [7:0]  data_in = 8'd0;
    logic [15:0] ret_addr = 16'd0;
    logic        ram_we, ram_re, busy, done;
    logic [7:0]  ram_addr, ram_wdata, ram_rdata, pop_data, sp;
    logic [15:0] ret_pc;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    stack_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .data_in(data_in), .ret_addr(ret_addr), .ram_we(ram_we), .ram_re(ram_re),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .busy(busy), .done(done), .pop_data(pop_data), .ret_pc(ret_pc), .sp(sp)
    );

    // Bench-side data RAM with combinational read.
    logic [7:0] mem [256];
    initial for (int i = 0; i < 256; i++) mem[i] = 8'd0;
    always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;
    assign ram_rdata = mem[ram_addr];

    // Behavioural reference: a queue of pending byte moves.
    // bit 8 = write, bit 9 = read belongs to a return, bits 7:0 = write byte.
    int q[$];
    int sp_m, pop_m, ret_m;
    bit done_m;
    int mm [256];
    initial for (int i = 0; i < 256; i++) mm[i] = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.delete();
            sp_m = 7; pop_m = 0; ret_m = 0; done_m = 0;
        end else begin
            done_m = 0;
            if (q.size() != 0) begin
                int e, b;
                e = q.pop_front();
                if (e[8]) begin
                    sp_m = (sp_m + 1) & 255;
                    mm[sp_m] = e & 255;
                end else begin
                    b = mm[sp_m];
                    if (e[9]) ret_m = ((ret_m << 8) | b) & 16'hFFFF;
                    else pop_m = b;
                    sp_m = (sp_m - 1) & 255;
                end
                if (q.size() == 0) done_m = 1;
            end else if (op_valid) begin
                case (op_code)
                    3'd1: q.push_back(256 | int'(data_in));
                    3'd2: q.push_back(0);
                    3'd3: begin
                        q.push_back(256 | int'(ret_addr[7:0]));
                        q.push_back(256 | int'(ret_addr[15:8]));
                    end
                    3'd4: begin q.push_back(512); q.push_back(512); end
                    3'd5: begin sp_m = int'(data_in); done_m = 1; end
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference, away from the clock edge.
    always @(negedge clk) begin
        if (rst_n) begin
            bit eb, ew, er;
            int ea;
            eb = (q.size() != 0);
            ew = eb && q[0][8];
            er = eb && !q[0][8];
            ea = ew ? ((sp_m + 1) & 255) : sp_m;
            check("R8 pointer", int'(sp), sp_m);
            check("R9 busy", int'(busy), int'(eb));
            check("R7 done", int'(done), int'(done_m));
            check("R2 write strobe", int'(ram_we), int'(ew));
            check("R3 read strobe", int'(ram_re), int'(er));
            if (ew || er) check("R2 address", int'(ram_addr), ea);
            if (ew) check("R4 write data", int'(ram_wdata), q[0] & 255);
            check("R3 pop data", int'(pop_data), pop_m);
            check("R5 return pc", int'(ret_pc), ret_m);
        end
    end

    task automatic issue(input logic [2:0] code, input logic [7:0] d, input logic [15:0] ra);
        @(negedge clk); #2;
        op_valid = 1'b1; op_code = code; data_in = d; ret_addr = ra;
        @(posedge clk); #2;
        op_valid = 1'b0; op_code = 3'd0;
    endtask

    task automatic wait_done(input string tag);
        bit seen;
        seen = 0;
        for (int k = 0; k < 10 && !seen; k++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        check(tag, int'(seen), 1);
    endtask

    task automatic run_tests();
        bit any_done;
        repeat (3) @(negedge clk);
        check("R1 pointer", int'(sp), 8'h07);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 port", int'(ram_we | ram_re), 0);
        #2 rst_n = 1'b1;

        issue(3'd1, 8'hA5, 16'h0);
        wait_done("R2 push done");
        check("R2 first push lands at 08", int'(mem[8]), 8'hA5);
        check("R2 pointer", int'(sp), 8'h08);

        issue(3'd1, 8'h3C, 16'h0);
        wait_done("R2 push done");
        issue(3'd2, 8'h00, 16'h0);
        wait_done("R3 pop done");
        check("R3 popped byte", int'(pop_data), 8'h3C);
        check("R3 pointer", int'(sp), 8'h08);

        issue(3'd3, 8'h00, 16'h1234);
        wait_done("R4 call done");
        check("R4 low byte first", int'(mem[9]), 8'h34);
        check("R4 high byte second", int'(mem[10]), 8'h12);
        check("R4 pointer", int'(sp), 8'h0A);

        // Call, with a push request presented during its busy cycle.
        issue(3'd3, 8'h00, 16'hBEEF);
        @(negedge clk); #2;
        op_valid = 1'b1; op_code = 3'd1; data_in = 8'h77;
        @(posedge clk); #2;
        op_valid = 1'b0; op_code = 3'd0;
        wait_done("R4 call done");
        check("R9 push while busy ignored", int'(sp), 8'h0C);
        check("R9 no stray write", int'(mem[13]), 8'h00);

        issue(3'd4, 8'h00, 16'h0);
        wait_done("R5 return done");
        check("R5 inner return", int'(ret_pc), 16'hBEEF);
        issue(3'd4, 8'h00, 16'h0);
        wait_done("R5 return done");
        check("R5 outer return", int'(ret_pc), 16'h1234);
        check("R5 pointer", int'(sp), 8'h08);

        issue(3'd6, 8'h55, 16'h0);
        any_done = 0;
        repeat (4) begin @(negedge clk); if (done || ram_we || ram_re) any_done = 1; end
        check("R9 unused code ignored", int'(any_done), 0);
        check("R9 pointer unchanged", int'(sp), 8'h08);

        issue(3'd5, 8'hFE, 16'h0);
        @(negedge clk);
        check("R6 done next cycle", int'(done), 1);
        check("R6 no busy", int'(busy), 0);
        check("R6 pointer loaded", int'(sp), 8'hFE);

        issue(3'd1, 8'h11, 16'h0);
        wait_done("R2 push done");
        issue(3'd1, 8'h22, 16'h0);
        wait_done("R8 push done");
        check("R8 byte at FF", int'(mem[255]), 8'h11);
        check("R8 wrap to 00", int'(mem[0]), 8'h22);
        check("R8 pointer", int'(sp), 8'h00);
        issue(3'd2, 8'h00, 16'h0);
        wait_done("R8 pop done");
        check("R8 pop at 00", int'(pop_data), 8'h22);
        check("R8 pointer back to FF", int'(sp), 8'hFF);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule